// File: doc/BRIEF.md
# Root-Hub Port Status and Control Registers

This block holds one 16-bit status/control word for each downstream port of a host controller's root hub. A port front end supplies the attachment state, a low-speed detect, the two data-line levels and a resume indication. Software reads and writes each port's word through a simple register bus. Port 0's word sits at byte offset 0x10, and each further port follows two bytes on.

Two flags record events: a change in attachment, and a hardware-caused loss of enable. Each flag stays set until software writes a 1 to its bit. Several bits report the live line levels and cannot be written. The enable, bus-reset and suspend controls are driven out to the port front end. A write lands only when it is a full 16-bit word at an even address.

Top module: `hub_port_regs`

## Requirements
- R1: Port k's word is read and written at byte offset 0x10+2k. A read of any other address, including odd ones, returns 0, and a write there changes nothing. Bit 0 shows the connect input as sampled on the previous clock edge.
- R2: Any change of a port's connect input, in either direction, sets bit 1 on the next edge.
- R3: A write with bit 1 = 1 clears bit 1, and a write with bit 1 = 0 leaves it unchanged. If a connect change occurs in the same cycle as the clearing write, bit 1 stays set.
- R4: When an enabled port is disconnected, bit 2 clears and bit 3 sets on the next edge. A write with bit 3 = 1 clears bit 3.
- R5: A write sets or clears enable (bit 2, mirrored on port_enable_o) to the written value, and this never sets bit 3.
- R6: Bits 4, 5, 6 and 8 show dminus_i, dplus_i, resume_i and low_speed_i live. Writes to these bits have no effect.
- R7: Bit 9 (port_reset_o) is written by software. While it is 1, enable reads 0 and stays 0 even when a 1 is written to bit 2. Connect status is still reported.
- R8: Bit 12 (port_suspend_o) takes the written value and holds it until the next write.
- R9: Bits 7, 10, 11, 13, 14 and 15 always read 0, whatever is written.
- R10: A write with wr_word_i = 0 changes no state.
- R11: A single write that carries a 1 in a change bit and new control values both clears the flag and applies the controls in the same cycle.
- R12: After reset, every stored bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address for the read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_word_i | input | 1 | High when the access is a full 16-bit word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| connect_i | input | NUM_PORTS | Device attached, one bit per port |
| low_speed_i | input | NUM_PORTS | Low-speed device detected |
| dplus_i | input | NUM_PORTS | D+ line level |
| dminus_i | input | NUM_PORTS | D- line level |
| resume_i | input | NUM_PORTS | Resume signalling detected |
| port_enable_o | output | NUM_PORTS | Port enabled |
| port_reset_o | output | NUM_PORTS | Drive bus reset on the port |
| port_suspend_o | output | NUM_PORTS | Port suspended |

## Verification
A connect or disconnect event can land in the same cycle as a software write that clears the change flags or rewrites the enable. The bench provokes this in two ways. It toggles connect_i in the same cycle as a write of 1 to bit 1, and it disconnects an enabled port while a write sets bit 2. It also keeps up a long stretch where line events and random writes overlap freely. Each cycle is judged against a behavioural model in which a hardware event beats a software clear and a disconnect beats a software enable.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;
  localparam int REG_W = 16;

  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_DMINUS   = 4;
  localparam int B_DPLUS    = 5;
  localparam int B_RESUME   = 6;
  localparam int B_LOWSPD   = 8;
  localparam int B_RST      = 9;
  localparam int B_SUSP     = 12;

  typedef struct packed {
    logic conn;
    logic conn_chg;
    logic en;
    logic en_chg;
    logic rst;
    logic susp;
  } port_state_t;

  typedef struct packed {
    logic clr_conn_chg;
    logic en;
    logic clr_en_chg;
    logic rst;
    logic susp;
  } port_ctl_t;

  typedef struct packed {
    logic low_speed;
    logic resume;
    logic dplus;
    logic dminus;
  } port_line_t;
endpackage

// File: rtl/hub_port_decode.sv
module hub_port_decode #(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int BASE      = 16
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_PORTS-1:0] sel_o
);
  localparam int STRIDE = 2;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_sel
    assign sel_o[k] = (addr_i == ADDR_W'(BASE + STRIDE * k));
  end
endmodule

// File: rtl/hub_port_cell.sv
module hub_port_cell
  import hub_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  port_ctl_t        ctl_i,
  input  logic             connect_i,
  input  port_line_t       line_i,
  output port_state_t      state_o,
  output logic [REG_W-1:0] word_o
);
  port_state_t q, d;
  logic conn_evt, disc_evt;

  assign conn_evt = connect_i ^ q.conn;
  assign disc_evt = q.conn & ~connect_i;

  always_comb begin
    d      = q;
    d.conn = connect_i;
    if (wr_i) begin
      d.en   = ctl_i.en;
      d.rst  = ctl_i.rst;
      d.susp = ctl_i.susp;
      if (ctl_i.clr_conn_chg) d.conn_chg = 1'b0;
      if (ctl_i.clr_en_chg)   d.en_chg   = 1'b0;
    end
    // hardware events take priority over software clears and enables
    if (conn_evt) d.conn_chg = 1'b1;
    if (disc_evt && q.en) d.en_chg = 1'b1;
    if (disc_evt || d.rst) d.en = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  always_comb begin
    word_o             = '0;
    word_o[B_CONN]     = q.conn;
    word_o[B_CONN_CHG] = q.conn_chg;
    word_o[B_EN]       = q.en;
    word_o[B_EN_CHG]   = q.en_chg;
    word_o[B_DMINUS]   = line_i.dminus;
    word_o[B_DPLUS]    = line_i.dplus;
    word_o[B_RESUME]   = line_i.resume;
    word_o[B_LOWSPD]   = line_i.low_speed;
    word_o[B_RST]      = q.rst;
    word_o[B_SUSP]     = q.susp;
  end

  assign state_o = q;
endmodule

// File: rtl/hub_port_rdmux.sv
module hub_port_rdmux #(
  parameter int NUM_PORTS = 2,
  parameter int REG_W     = 16
) (
  input  logic [NUM_PORTS-1:0]            sel_i,
  input  logic [NUM_PORTS-1:0][REG_W-1:0] words_i,
  output logic [REG_W-1:0]                rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (sel_i[k]) rdata_o = rdata_o | words_i[k];
    end
  end
endmodule

// File: rtl/hub_port_regs.sv
module hub_port_regs
  import hub_port_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int BASE      = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic                 wr_word_i,
  input  logic [15:0]          wdata_i,
  output logic [15:0]          rdata_o,
  input  logic [NUM_PORTS-1:0] connect_i,
  input  logic [NUM_PORTS-1:0] low_speed_i,
  input  logic [NUM_PORTS-1:0] dplus_i,
  input  logic [NUM_PORTS-1:0] dminus_i,
  input  logic [NUM_PORTS-1:0] resume_i,
  output logic [NUM_PORTS-1:0] port_enable_o,
  output logic [NUM_PORTS-1:0] port_reset_o,
  output logic [NUM_PORTS-1:0] port_suspend_o
);
  logic [NUM_PORTS-1:0]            sel;
  logic [NUM_PORTS-1:0][REG_W-1:0] words;
  logic [NUM_PORTS-1:0]            conn_vec, csc_vec, pedc_vec;
  logic                            wr_fire;
  port_ctl_t                       ctl;
  logic                            wr_unused;

  assign wr_fire = wr_en_i & wr_word_i;

  assign ctl.clr_conn_chg = wdata_i[B_CONN_CHG];
  assign ctl.en           = wdata_i[B_EN];
  assign ctl.clr_en_chg   = wdata_i[B_EN_CHG];
  assign ctl.rst          = wdata_i[B_RST];
  assign ctl.susp         = wdata_i[B_SUSP];
  assign wr_unused = ^{wdata_i[15:13], wdata_i[11:10], wdata_i[8:4], wdata_i[0]};

  hub_port_decode #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    port_state_t st;
    port_line_t  ln;
    assign ln.low_speed = low_speed_i[k];
    assign ln.resume    = resume_i[k];
    assign ln.dplus     = dplus_i[k];
    assign ln.dminus    = dminus_i[k];

    hub_port_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_fire & sel[k]),
      .ctl_i    (ctl),
      .connect_i(connect_i[k]),
      .line_i   (ln),
      .state_o  (st),
      .word_o   (words[k])
    );

    assign port_enable_o[k]  = st.en;
    assign port_reset_o[k]   = st.rst;
    assign port_suspend_o[k] = st.susp;
    assign conn_vec[k]       = st.conn;
    assign csc_vec[k]        = st.conn_chg;
    assign pedc_vec[k]       = st.en_chg;
  end

  hub_port_rdmux #(
    .NUM_PORTS(NUM_PORTS), .REG_W(REG_W)
  ) u_rd (
    .sel_i  (sel),
    .words_i(words),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/hub_port_chk.sv
module hub_port_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic                 wr_word_i,
  input logic [15:0]          rdata_o,
  input logic [NUM_PORTS-1:0] connect_i,
  input logic [NUM_PORTS-1:0] port_enable_o,
  input logic [NUM_PORTS-1:0] port_reset_o,
  input logic [NUM_PORTS-1:0] port_suspend_o,
  input logic [NUM_PORTS-1:0] conn_vec,
  input logic [NUM_PORTS-1:0] csc_vec,
  input logic [NUM_PORTS-1:0] pedc_vec
);
  localparam logic [15:0] RSVD_MASK = 16'hEC80;

  p_rsvd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RSVD_MASK) == 16'h0);

  p_byte_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_word_i) |=> ($stable(port_reset_o) && $stable(port_suspend_o)));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
    p_conn_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> conn_vec[k] == $past(connect_i[k]));

    p_conn_chg_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (connect_i[k] != conn_vec[k]) |=> csc_vec[k]);

    p_disc_disable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conn_vec[k] && !connect_i[k] && port_enable_o[k]) |=> (!port_enable_o[k] && pedc_vec[k]));

    p_reset_holds_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_reset_o[k] |-> !port_enable_o[k]);
  end
endmodule

bind hub_port_regs hub_port_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_word_i     (wr_word_i),
  .rdata_o       (rdata_o),
  .connect_i     (connect_i),
  .port_enable_o (port_enable_o),
  .port_reset_o  (port_reset_o),
  .port_suspend_o(port_suspend_o),
  .conn_vec      (conn_vec),
  .csc_vec       (csc_vec),
  .pedc_vec      (pedc_vec)
);

// File: tb/sim_hub_port_regs.sv
module sim_hub_port_regs;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0, wr_word = 1'b0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NP-1:0] conn = '0, ls = '0, dp = '0, dm = '0, res = '0;
  logic [NP-1:0] en_o, rst_o, susp_o;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_conn[NP], m_csc[NP], m_en[NP], m_pedc[NP], m_rst[NP], m_susp[NP];
  bit n_conn[NP], n_csc[NP], n_en[NP], n_pedc[NP], n_rst[NP], n_susp[NP];

  always #5 clk = ~clk;

  hub_port_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_word_i(wr_word),
    .wdata_i(wdata), .rdata_o(rdata), .connect_i(conn), .low_speed_i(ls),
    .dplus_i(dp), .dminus_i(dm), .resume_i(res),
    .port_enable_o(en_o), .port_reset_o(rst_o), .port_suspend_o(susp_o)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic int port_of(input int a);
    if (a >= 16 && a < 16 + 2 * NP && a[0] == 1'b0) return (a - 16) / 2;
    return -1;
  endfunction

  function automatic logic [15:0] model_word(input int a);
    int p;
    logic [15:0] w;
    p = port_of(a);
    w = '0;
    if (p >= 0) begin
      w[0] = m_conn[p]; w[1] = m_csc[p]; w[2] = m_en[p]; w[3] = m_pedc[p];
      w[4] = dm[p]; w[5] = dp[p]; w[6] = res[p]; w[8] = ls[p];
      w[9] = m_rst[p]; w[12] = m_susp[p];
    end
    return w;
  endfunction

  task automatic tick(input string tag, input bit we, input bit word, input int a,
                      input logic [15:0] d);
    logic [NP-1:0] e_en, e_rst, e_susp;
    @(negedge clk);
    wr_en = we; wr_word = word; addr = a[7:0]; wdata = d;
    for (int p = 0; p < NP; p++) begin
      bit wr, disc;
      wr   = we && word && (port_of(a) == p);
      disc = m_conn[p] && !conn[p];
      n_conn[p] = conn[p];
      n_rst[p]  = wr ? d[9]  : m_rst[p];
      n_susp[p] = wr ? d[12] : m_susp[p];
      n_en[p]   = wr ? d[2]  : m_en[p];
      if (disc || n_rst[p]) n_en[p] = 0;
      n_csc[p] = m_csc[p];
      if (wr && d[1]) n_csc[p] = 0;
      if (conn[p] != m_conn[p]) n_csc[p] = 1;
      n_pedc[p] = m_pedc[p];
      if (wr && d[3]) n_pedc[p] = 0;
      if (disc && m_en[p]) n_pedc[p] = 1;
    end
    @(posedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      m_conn[p] = n_conn[p]; m_csc[p] = n_csc[p]; m_en[p] = n_en[p];
      m_pedc[p] = n_pedc[p]; m_rst[p] = n_rst[p]; m_susp[p] = n_susp[p];
      e_en[p] = m_en[p]; e_rst[p] = m_rst[p]; e_susp[p] = m_susp[p];
    end
    check(tag, "controls", int'({en_o, rst_o, susp_o}), int'({e_en, e_rst, e_susp}));
    check(tag, "rdata", int'(rdata), int'(model_word(a)));
  endtask

  task automatic wr(input string tag, input int a, input logic [15:0] d);
    tick(tag, 1, 1, a, d);
  endtask

  task automatic rd(input string tag, input int a);
    tick(tag, 0, 1, a, 16'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: all zero after reset
    rd("R12", 16'h10);
    rd("R12", 16'h12);
    // R1, R2: connect port 0
    conn[0] = 1'b1;
    rd("R2", 16'h10);
    rd("R1", 16'h10);
    check("R1", "conn bit", int'(rdata[0]), 1);
    // R3: write 0 keeps flag, write 1 clears
    wr("R3", 16'h10, 16'h0000);
    check("R3", "csc kept", int'(rdata[1]), 1);
    wr("R3", 16'h10, 16'h0002);
    check("R3", "csc cleared", int'(rdata[1]), 0);
    // R5: software enable does not set change flag
    wr("R5", 16'h10, 16'h0004);
    check("R5", "enabled no pedc", int'(rdata[3:2]), 1);
    wr("R5", 16'h10, 16'h0000);
    wr("R5", 16'h10, 16'h0004);
    // R6: live line bits on port 1, writes ignored
    dm[1] = 1'b1; dp[1] = 1'b0; res[1] = 1'b1; ls[1] = 1'b1;
    rd("R6", 16'h12);
    check("R6", "live bits", int'(rdata), 16'h0150);
    wr("R6", 16'h12, 16'h0020);
    dp[1] = 1'b1; dm[1] = 1'b0;
    rd("R6", 16'h12);
    // R4: disconnect enabled port 0
    conn[0] = 1'b0;
    rd("R4", 16'h10);
    check("R4", "en/pedc", int'(rdata[3:1]), 3'b101);
    wr("R4", 16'h10, 16'h0008);
    check("R4", "pedc cleared", int'(rdata[3]), 0);
    // R3: reconnect in the same cycle as a clear of bit 1
    conn[0] = 1'b1;
    wr("R3", 16'h10, 16'h0002);
    check("R3", "event beats clear", int'(rdata[1]), 1);
    // disconnect racing a software enable
    wr("R5", 16'h10, 16'h0004);
    conn[0] = 1'b0;
    wr("R4", 16'h10, 16'h0004);
    check("R4", "disc beats enable", int'(rdata[2]), 0);
    conn[0] = 1'b1;
    rd("R2", 16'h10);
    // R11: clear flags and set controls together
    wr("R11", 16'h10, 16'h100E);
    check("R11", "combined", int'(rdata[3:0]), 4'b0101);
    // R8: suspend
    check("R8", "suspend out", int'(susp_o[0]), 1);
    // R7: reset holds disabled, connect still reported
    wr("R7", 16'h10, 16'h0204);
    check("R7", "reset disables", int'(rdata[2]), 0);
    check("R7", "conn reported", int'(rdata[0]), 1);
    // R10: byte-sized write ignored
    tick("R10", 1, 0, 16'h10, 16'h0004);
    check("R10", "reset kept", int'(rst_o[0]), 1);
    // R9: reserved bits read zero
    wr("R9", 16'h10, 16'hFFFF);
    check("R9", "reserved", int'(rdata & 16'hEC80), 0);
    // R1: unmapped and odd addresses
    wr("R1", 16'h14, 16'h1204);
    wr("R1", 16'h11, 16'h1204);
    rd("R1", 16'h11);
    rd("R1", 16'h14);
    // R8: clear suspend and reset
    wr("R8", 16'h10, 16'h0000);
    wr("R8", 16'h12, 16'h1000);
    // mixed traffic with overlapping line events
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [15:0] d;
      if ($urandom_range(0, 5) == 0) conn = NP'($urandom);
      if ($urandom_range(0, 3) == 0) {ls, dp, dm, res} = 8'($urandom);
      a = 16 + int'($urandom_range(0, 5));
      d = 16'($urandom);
      if ($urandom_range(0, 2) == 0) d[9] = 1'b0;
      tick("R11", $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, a, d);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule